// File: doc/BRIEF.md
# Coherence Directory with Targeted Snooping

The block is the tag directory of a shared last-level cache that sits in front of up to four cores. For every line that any core holds in its private caches, it keeps an entry with the line address, a bit per core telling which cores hold a copy, and whether one core may hold the line dirty, along with that core's number. Read and read-for-ownership requests arrive one at a time. The directory looks up the line and sends snoops only to the cores that must act: the single owner for a read, or the other holders for a read-for-ownership. It answers the requester with a grant of Shared or Exclusive.

Dirty data never moves into the directory. A core granted Exclusive may modify the line silently, so the directory treats that core as owner until a snoop downgrades it. The array is small and fully associative. When it is full and a new line arrives, a victim entry is picked in rotation. All holders of the victim are invalidated so that inclusion is kept, and then the request proceeds as a miss.

A single controller runs every request to completion. Its states are IDLE (ready for a request), CHECK (look up the captured line and decide the snoop set), SNOOP (one-cycle snoop pulse to the target cores), WAIT (collect acknowledges), EVICT (free the victim entry and advance the rotation pointer) and GRANT (write the entry and pulse the grant). The transitions are IDLE to CHECK on a request. CHECK goes to SNOOP when some core must be snooped, otherwise to GRANT. SNOOP goes to WAIT. WAIT goes to EVICT or GRANT once no acknowledge is outstanding. EVICT returns to CHECK, and GRANT returns to IDLE.

Top module: `snoop_dir`

## Requirements
- R1: After reset, req_ready is 1 and snp_valid and gnt_valid are 0.
- R2: A read (req_kind 0) to a line held by no core sends no snoop and is granted Exclusive (gnt_state 1).
- R3: A read to a line that another core holds Exclusive/Modified sends a downgrade snoop (snp_kind 0) to that core alone. The read is granted Shared (gnt_state 0) only after that core acknowledges.
- R4: A read to a line held only in Shared by other cores sends no snoop and is granted Shared.
- R5: A read-for-ownership (req_kind 1) sends an invalidate snoop (snp_kind 1) to every other core that holds the line and never to the requester. It is granted Exclusive.
- R6: A read-for-ownership to a line held by no other core sends no snoop and is granted Exclusive.
- R7: No grant is issued while any snoop acknowledge is outstanding, and req_ready stays 0 from acceptance until the grant (later requests stall).
- R8: After a downgrade, both the former owner and the reader are recorded as holders, and a later read-for-ownership invalidates both of them.
- R9: When all entries are valid and a new line is requested, the victim entries are taken in rotation starting from entry 0. Entries fill from the lowest free index. Every holder of the victim receives an invalidate carrying the victim's line address before the request is granted as a miss.
- R10: Coherence snoops carry the requested line address on snp_addr. snp_valid bit i addresses core i.
- R11: gnt_valid is a one-cycle pulse and gnt_core equals the requesting core.
- R12: A line address occupies at most one directory entry, and every valid entry has at least one holder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_core | input | 2 | Requesting core number |
| req_kind | input | 1 | 0 read, 1 read-for-ownership |
| req_addr | input | 16 | Line address |
| snp_valid | output | 4 | One-cycle snoop pulse, bit per core |
| snp_kind | output | 1 | 0 downgrade to Shared, 1 invalidate |
| snp_addr | output | 16 | Line address being snooped |
| snp_ack | input | 4 | Snoop acknowledge, bit per core |
| gnt_valid | output | 1 | Grant pulse |
| gnt_core | output | 2 | Core receiving the grant |
| gnt_state | output | 1 | 0 Shared, 1 Exclusive |

## Verification
On every cycle, the assertions check that a downgrade reaches exactly one core, that an invalidate for coherence spares the requester, and that no grant coincides with pending acknowledges. They also check that requests stall while snoops are outstanding, that the grant is a single pulse, and that the array never holds a line twice or an entry without holders. Only the directed scenarios can show that the right set of cores is chosen from the recorded history. This covers owner tracking across a downgrade, invalidation of all sharers and the rotation order of victims. The scenarios also check the Shared or Exclusive grant each access pattern earns.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic {REQ_RD = 1'b0, REQ_RFO = 1'b1} req_kind_e;
    typedef enum logic {SNP_DOWN = 1'b0, SNP_INV = 1'b1} snp_kind_e;
    typedef enum logic {GNT_SHR = 1'b0, GNT_EXC = 1'b1} gnt_state_e;
    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_SNOOP, ST_WAIT, ST_EVICT, ST_GRANT
    } dir_state_e;
endpackage

// File: rtl/dir_array.sv
module dir_array #(
    parameter int NCORE = 4,
    parameter int DEPTH = 4,
    parameter int AW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            lk_addr,
    output logic                     lk_hit,
    output logic [$clog2(DEPTH)-1:0] lk_hit_idx,
    output logic                     lk_free_ok,
    output logic [$clog2(DEPTH)-1:0] lk_free_idx,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [AW-1:0]            rd_tag,
    output logic [NCORE-1:0]         rd_pres,
    output logic                     rd_own,
    output logic [$clog2(NCORE)-1:0] rd_oid,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic                     wr_valid,
    input  logic [AW-1:0]            wr_tag,
    input  logic [NCORE-1:0]         wr_pres,
    input  logic                     wr_own,
    input  logic [$clog2(NCORE)-1:0] wr_oid
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(NCORE);

    logic [DEPTH-1:0]       v_q;
    logic [AW-1:0]          tag_q  [DEPTH];
    logic [NCORE-1:0]       pres_q [DEPTH];
    logic [DEPTH-1:0]       own_q;
    logic [CW-1:0]          oid_q  [DEPTH];
    logic [DEPTH-1:0]       match;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_ent
            assign match[g] = v_q[g] && (tag_q[g] == lk_addr);
            // every tracked line has a holder
            assert_entry_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
                v_q[g] |-> (pres_q[g] != '0));
        end
    endgenerate

    // lowest matching and lowest free index
    always_comb begin
        lk_hit      = 1'b0;
        lk_hit_idx  = '0;
        lk_free_ok  = 1'b0;
        lk_free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_hit     = 1'b1;
                lk_hit_idx = IW'(i);
            end
            if (!v_q[i]) begin
                lk_free_ok  = 1'b1;
                lk_free_idx = IW'(i);
            end
        end
    end

    assign rd_tag  = tag_q[rd_idx];
    assign rd_pres = pres_q[rd_idx];
    assign rd_own  = own_q[rd_idx];
    assign rd_oid  = oid_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q   <= '0;
            own_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tag_q[i]  <= '0;
                pres_q[i] <= '0;
                oid_q[i]  <= '0;
            end
        end else if (wr_en) begin
            v_q[wr_idx]    <= wr_valid;
            tag_q[wr_idx]  <= wr_tag;
            pres_q[wr_idx] <= wr_valid ? wr_pres : '0;
            own_q[wr_idx]  <= wr_valid & wr_own;
            oid_q[wr_idx]  <= wr_oid;
        end
    end

    assert_unique_line_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/snoop_track.sv
module snoop_track #(
    parameter int NCORE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NCORE-1:0] load_mask,
    input  logic [NCORE-1:0] ack,
    output logic             busy
);
    logic [NCORE-1:0] pending_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= (load ? load_mask : pending_q) & ~ack;
    end

    assign busy = |pending_q;

    // outstanding set only grows when a snoop is launched
    assert_no_new_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((pending_q & ~$past(pending_q)) == '0));
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
    import coh_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int DEPTH = 4,
    parameter int AW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [$clog2(NCORE)-1:0] req_core,
    input  logic                     req_kind,
    input  logic [AW-1:0]            req_addr,
    output logic [AW-1:0]            lk_addr,
    input  logic                     lk_hit,
    input  logic [$clog2(DEPTH)-1:0] lk_hit_idx,
    input  logic                     lk_free_ok,
    input  logic [$clog2(DEPTH)-1:0] lk_free_idx,
    output logic [$clog2(DEPTH)-1:0] rd_idx,
    input  logic [AW-1:0]            rd_tag,
    input  logic [NCORE-1:0]         rd_pres,
    input  logic                     rd_own,
    input  logic [$clog2(NCORE)-1:0] rd_oid,
    output logic                     wr_en,
    output logic [$clog2(DEPTH)-1:0] wr_idx,
    output logic                     wr_valid,
    output logic [AW-1:0]            wr_tag,
    output logic [NCORE-1:0]         wr_pres,
    output logic                     wr_own,
    output logic [$clog2(NCORE)-1:0] wr_oid,
    output logic                     trk_load,
    output logic [NCORE-1:0]         trk_mask,
    input  logic                     trk_busy,
    output logic [NCORE-1:0]         snp_valid,
    output logic                     snp_kind,
    output logic [AW-1:0]            snp_addr,
    output logic                     gnt_valid,
    output logic [$clog2(NCORE)-1:0] gnt_core,
    output logic                     gnt_state
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(NCORE);

    dir_state_e       state_q, state_d;
    logic [CW-1:0]    core_q;
    req_kind_e        kind_q;
    logic [AW-1:0]    addr_q;
    logic [NCORE-1:0] tgt_q, tgt_d;
    snp_kind_e        skind_q, skind_d;
    logic [AW-1:0]    saddr_q, saddr_d;
    logic             evict_q, evict_d;
    logic [IW-1:0]    idx_q, idx_d;
    logic [NCORE-1:0] pres_q;
    logic [IW-1:0]    rr_q;
    logic [NCORE-1:0] req_bit;
    logic [NCORE-1:0] others_g;
    gnt_state_e       gstate;

    assign req_bit = NCORE'(1) << core_q;
    assign lk_addr = addr_q;
    assign rd_idx  = lk_hit ? lk_hit_idx : rr_q;

    // snoop set decided from the looked-up entry
    always_comb begin
        tgt_d   = '0;
        skind_d = SNP_INV;
        saddr_d = addr_q;
        evict_d = 1'b0;
        idx_d   = lk_hit ? lk_hit_idx : lk_free_idx;
        if (lk_hit) begin
            if (kind_q == REQ_RD) begin
                if (rd_own && (rd_oid != core_q)) begin
                    tgt_d   = NCORE'(1) << rd_oid;
                    skind_d = SNP_DOWN;
                end
            end else begin
                tgt_d = rd_pres & ~req_bit;
            end
        end else if (!lk_free_ok) begin
            evict_d = 1'b1;
            idx_d   = rr_q;
            tgt_d   = rd_pres;
            saddr_d = rd_tag;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (tgt_d != '0)  state_d = ST_SNOOP;
                else if (evict_d) state_d = ST_EVICT;
                else              state_d = ST_GRANT;
            end
            ST_SNOOP: state_d = ST_WAIT;
            ST_WAIT:  if (!trk_busy) state_d = evict_q ? ST_EVICT : ST_GRANT;
            ST_EVICT: state_d = ST_CHECK;
            ST_GRANT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q  <= '0;
            kind_q  <= REQ_RD;
            addr_q  <= '0;
            tgt_q   <= '0;
            skind_q <= SNP_INV;
            saddr_q <= '0;
            evict_q <= 1'b0;
            idx_q   <= '0;
            pres_q  <= '0;
            rr_q    <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                core_q <= req_core;
                kind_q <= req_kind_e'(req_kind);
                addr_q <= req_addr;
            end
            if (state_q == ST_CHECK) begin
                tgt_q   <= tgt_d;
                skind_q <= skind_d;
                saddr_q <= saddr_d;
                evict_q <= evict_d;
                idx_q   <= idx_d;
                pres_q  <= lk_hit ? rd_pres : '0;
            end
            if (state_q == ST_EVICT) begin
                rr_q    <= (rr_q == IW'(DEPTH - 1)) ? '0 : rr_q + IW'(1);
                evict_q <= 1'b0;
            end
        end
    end

    // entry update computed for the grant
    always_comb begin
        others_g = pres_q & ~req_bit;
        if (kind_q == REQ_RFO || others_g == '0) begin
            gstate  = GNT_EXC;
            wr_pres = req_bit;
            wr_own  = 1'b1;
        end else begin
            gstate  = GNT_SHR;
            wr_pres = pres_q | req_bit;
            wr_own  = 1'b0;
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        snp_valid = (state_q == ST_SNOOP) ? tgt_q : '0;
        snp_kind  = skind_q;
        snp_addr  = saddr_q;
        gnt_valid = (state_q == ST_GRANT);
        gnt_core  = core_q;
        gnt_state = gstate;
        trk_load  = (state_q == ST_SNOOP);
        trk_mask  = tgt_q;
        wr_en     = (state_q == ST_GRANT) || (state_q == ST_EVICT);
        wr_valid  = (state_q == ST_GRANT);
        wr_idx    = idx_q;
        wr_tag    = addr_q;
        wr_oid    = core_q;
    end

    assert_grant_after_acks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> !trk_busy);
    assert_stall_while_snooping_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trk_busy |-> !req_ready);
    assert_downgrade_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((snp_valid != '0) && snp_kind == SNP_DOWN) |-> $onehot(snp_valid));
    assert_requester_spared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((snp_valid != '0) && !evict_q) |-> !snp_valid[core_q]);
    assert_snoop_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((snp_valid != '0) && !evict_q) |-> (snp_addr == addr_q));
    assert_grant_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> !gnt_valid);
endmodule

// File: rtl/snoop_dir.sv
module snoop_dir #(
    parameter int NCORE = 4,
    parameter int DEPTH = 4,
    parameter int AW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [$clog2(NCORE)-1:0] req_core,
    input  logic                     req_kind,
    input  logic [AW-1:0]            req_addr,
    output logic [NCORE-1:0]         snp_valid,
    output logic                     snp_kind,
    output logic [AW-1:0]            snp_addr,
    input  logic [NCORE-1:0]         snp_ack,
    output logic                     gnt_valid,
    output logic [$clog2(NCORE)-1:0] gnt_core,
    output logic                     gnt_state
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(NCORE);

    logic [AW-1:0]    lk_addr;
    logic             lk_hit, lk_free_ok;
    logic [IW-1:0]    lk_hit_idx, lk_free_idx, rd_idx, wr_idx;
    logic [AW-1:0]    rd_tag, wr_tag;
    logic [NCORE-1:0] rd_pres, wr_pres, trk_mask;
    logic             rd_own, wr_en, wr_valid, wr_own, trk_load, trk_busy;
    logic [CW-1:0]    rd_oid, wr_oid;

    dir_array #(.NCORE(NCORE), .DEPTH(DEPTH), .AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_hit_idx(lk_hit_idx),
        .lk_free_ok(lk_free_ok), .lk_free_idx(lk_free_idx),
        .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_pres(rd_pres),
        .rd_own(rd_own), .rd_oid(rd_oid),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_tag(wr_tag),
        .wr_pres(wr_pres), .wr_own(wr_own), .wr_oid(wr_oid)
    );

    snoop_track #(.NCORE(NCORE)) u_track (
        .clk(clk), .rst_n(rst_n), .load(trk_load), .load_mask(trk_mask),
        .ack(snp_ack), .busy(trk_busy)
    );

    dir_ctrl #(.NCORE(NCORE), .DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core),
        .req_kind(req_kind), .req_addr(req_addr),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_hit_idx(lk_hit_idx),
        .lk_free_ok(lk_free_ok), .lk_free_idx(lk_free_idx),
        .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_pres(rd_pres),
        .rd_own(rd_own), .rd_oid(rd_oid),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_tag(wr_tag),
        .wr_pres(wr_pres), .wr_own(wr_own), .wr_oid(wr_oid),
        .trk_load(trk_load), .trk_mask(trk_mask), .trk_busy(trk_busy),
        .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
        .gnt_valid(gnt_valid), .gnt_core(gnt_core), .gnt_state(gnt_state)
    );
endmodule

// File: tb/test_snoop_dir.sv
module test_snoop_dir;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_core = '0;
    logic        req_kind = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  snp_valid;
    logic        snp_kind;
    logic [15:0] snp_addr;
    logic [3:0]  snp_ack = '0;
    logic        gnt_valid;
    logic [1:0]  gnt_core;
    logic        gnt_state;

    int n_cmp = 0;
    int n_bad = 0;

    logic [3:0]  r_mask;
    logic        r_kind;
    logic [15:0] r_addr;
    logic [1:0]  r_gcore;
    logic        r_gstate;
    logic        r_gnt_seen, r_order_ok, r_ready_leak, r_pulse_ok;

    localparam logic RD = 1'b0, RFO = 1'b1;
    localparam logic SHR = 1'b0, EXC = 1'b1;
    localparam logic DOWN = 1'b0, INV = 1'b1;
    localparam logic [15:0] LA = 16'h0100, LB = 16'h0200, LC = 16'h0300,
                            LD = 16'h0400, LE = 16'h0500;

    always #4 clk = ~clk;

    snoop_dir i_snoop_dir (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_core(req_core), .req_kind(req_kind), .req_addr(req_addr),
        .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
        .snp_ack(snp_ack), .gnt_valid(gnt_valid), .gnt_core(gnt_core),
        .gnt_state(gnt_state)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // issue one request, answer snoops with staggered acks, capture the grant
    task automatic run_req(input logic [1:0] core, input logic kind, input logic [15:0] addr);
        int due[4];
        int cyc;
        int last_due;
        r_mask = '0; r_kind = 1'b0; r_addr = '0; r_gcore = '0; r_gstate = 1'b0;
        r_gnt_seen = 1'b0; r_order_ok = 1'b1; r_ready_leak = 1'b0; r_pulse_ok = 1'b1;
        last_due = -1;
        cyc = 0;
        for (int i = 0; i < 4; i++) due[i] = -1;
        @(negedge clk);
        req_valid = 1'b1; req_core = core; req_kind = kind; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        while (!r_gnt_seen && cyc < 80) begin
            snp_ack = '0;
            if (snp_valid != '0) begin
                r_mask = r_mask | snp_valid;
                r_kind = snp_kind;
                r_addr = snp_addr;
                for (int i = 0; i < 4; i++)
                    if (snp_valid[i]) begin
                        due[i] = cyc + 2 + i;
                        if (due[i] > last_due) last_due = due[i];
                    end
            end
            if (gnt_valid) begin
                r_gnt_seen = 1'b1;
                r_gcore = gnt_core;
                r_gstate = gnt_state;
                if (cyc <= last_due) r_order_ok = 1'b0;
            end else if (req_ready) begin
                r_ready_leak = 1'b1;
            end
            for (int i = 0; i < 4; i++) if (due[i] == cyc) snp_ack[i] = 1'b1;
            if (!r_gnt_seen) begin
                @(negedge clk);
                cyc++;
            end
        end
        snp_ack = '0;
        @(negedge clk);
        if (gnt_valid) r_pulse_ok = 1'b0;
    endtask

    task automatic expect_common(input string rq, input logic [1:0] core, input logic st);
        check({rq, " grant seen"}, r_gnt_seen, 1);
        check({rq, "/R11 grant core"}, r_gcore, core);
        check({rq, " grant state"}, r_gstate, st);
        check({rq, "/R7 grant after acks"}, r_order_ok, 1);
        check({rq, "/R7 ready held low"}, r_ready_leak, 0);
        check({rq, "/R11 grant pulse"}, r_pulse_ok, 1);
    endtask

    task automatic t_reset_R1;
        check("R1 req_ready", req_ready, 1);
        check("R1 snp_valid", snp_valid, 0);
        check("R1 gnt_valid", gnt_valid, 0);
    endtask

    task automatic t_read_cold_R2;
        run_req(2'd0, RD, LA);
        check("R2 no snoop", r_mask, 4'b0000);
        expect_common("R2", 2'd0, EXC);
    endtask

    task automatic t_read_owned_R3;
        run_req(2'd1, RD, LA);
        check("R3 only owner snooped", r_mask, 4'b0001);
        check("R3 downgrade kind", r_kind, DOWN);
        check("R10 snoop addr", r_addr, LA);
        expect_common("R3", 2'd1, SHR);
    endtask

    task automatic t_read_shared_R4;
        run_req(2'd2, RD, LA);
        check("R4 no snoop", r_mask, 4'b0000);
        expect_common("R4", 2'd2, SHR);
    endtask

    task automatic t_rfo_sharers_R5_R8;
        run_req(2'd3, RFO, LA);
        check("R5/R8 all other holders", r_mask, 4'b0111);
        check("R5 invalidate kind", r_kind, INV);
        check("R10 snoop addr", r_addr, LA);
        expect_common("R5", 2'd3, EXC);
    endtask

    task automatic t_rfo_alone_R6;
        run_req(2'd3, RFO, LA);
        check("R6 owner re-rfo no snoop", r_mask, 4'b0000);
        expect_common("R6", 2'd3, EXC);
        run_req(2'd1, RFO, LB);
        check("R6 cold rfo no snoop", r_mask, 4'b0000);
        expect_common("R6", 2'd1, EXC);
    endtask

    task automatic t_evict_R9;
        run_req(2'd2, RD, LC);
        expect_common("R9 fill C", 2'd2, EXC);
        run_req(2'd0, RD, LD);
        expect_common("R9 fill D", 2'd0, EXC);
        // full: entry 0 (line A, core 3) is first victim
        run_req(2'd1, RD, LE);
        check("R9 first victim holders", r_mask, 4'b1000);
        check("R9 victim invalidate", r_kind, INV);
        check("R9 first victim addr", r_addr, LA);
        expect_common("R9 E", 2'd1, EXC);
        // next victim is entry 1 (line B, core 1)
        run_req(2'd0, RD, LA);
        check("R9 second victim holders", r_mask, 4'b0010);
        check("R9 second victim addr", r_addr, LB);
        expect_common("R9 A again", 2'd0, EXC);
        // line E was installed for core 1 as owner
        run_req(2'd2, RD, LE);
        check("R9/R3 owner of new line", r_mask, 4'b0010);
        check("R3 downgrade kind", r_kind, DOWN);
        check("R10 snoop addr", r_addr, LE);
        expect_common("R3", 2'd2, SHR);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_R1();
        t_read_cold_R2();
        t_read_owned_R3();
        t_read_shared_R4();
        t_rfo_sharers_R5_R8();
        t_rfo_alone_R6();
        t_evict_R9();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule